// File: doc/BRIEF.md
# Parallel Memory Bus Front End

This block connects an asynchronous parallel memory bus to a synchronous internal controller. The bus carries three active-low strobes (chip enable, write enable, output enable), a width select, an address bus and a bidirectional data bus. Each of these is brought into the clock domain through a two-stage synchroniser. The three strobes then pass through a filter, so that a level change counts only after it has been seen for `FILT_CYC` samples in a row.

A write is armed when the filtered strobes first show chip enable low, write enable low and output enable high. The address is taken at that moment, which is the falling edge of whichever enable went low last. The write completes when chip enable or write enable rises, whichever rises first. The data is taken at that point, and the block issues a single-clock request to the controller carrying the captured address and data.

Reads drive the data pins from the controller's read data while chip enable and output enable are low and write enable is high. In narrow (x8) mode only the low byte lanes are driven, and the top data pin is taken as the least significant address bit.

Top module: `pbf_front`

## Requirements
- R1: After reset, no write request is issued, every bit of `bus_dq_oe` is low, and all three strobes are treated as inactive (high).
- R2: A write is armed only while the filtered chip enable and write enable are both low and output enable is high. `wr_addr` holds the address sampled just before the later of the two falling edges. No write arises while output enable is low.
- R3: The data is the value on the data pins just before the earlier of the chip-enable and write-enable rising edges. `wr_req` is high for exactly one clock. It rises on the `FILT_CYC+1`-th clock edge after the edge that first samples the ending rise.
- R4: When chip enable and write enable rise in the same sample, exactly one write request results.
- R5: A low pulse on any strobe that lasts fewer than `FILT_CYC` consecutive samples is ignored: it starts no write and enables no drivers. A pulse of exactly `FILT_CYC` samples is accepted.
- R6: In wide mode (`bus_wide`=1), while the filtered strobes show a read (chip enable low, output enable low, write enable high), all 16 bits of `bus_dq_oe` are 1 and `bus_dq_out` equals `rd_data`.
- R7: With output enable high, or with chip enable high (standby), `bus_dq_oe` is all zero and `bus_dq_out` is zero.
- R8: In narrow mode (`bus_wide`=0), a read drives only bits 7..0 (`bus_dq_oe`=16'h00FF), with `rd_data[7:0]`. Bit 0 of both `rd_addr` and `wr_addr` is taken from `bus_dq_in[15]`; in wide mode that bit is 0. A narrow write sets `wr_byte`=1 and `wr_data`={8'h00, data[7:0]}.
- R9: If output enable falls while a write is armed, that write is cancelled: the later rise of chip enable or write enable issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_wide | input | 1 | 1 = x16 bus, 0 = x8 bus |
| bus_addr | input | ADDR_W | Word address pins |
| bus_dq_in | input | DATA_W | Data pins as seen by the input buffers |
| bus_dq_out | output | DATA_W | Data to drive onto the pins |
| bus_dq_oe | output | DATA_W | Per-bit output driver enable (0 = high impedance) |
| rd_addr | output | ADDR_W+1 | Synchronised read address, with the byte LSB in bit 0 |
| rd_data | input | DATA_W | Read data from the array controller |
| wr_req | output | 1 | One-clock write request |
| wr_addr | output | ADDR_W+1 | Captured write address, with the byte LSB in bit 0 |
| wr_data | output | DATA_W | Captured write data |
| wr_byte | output | 1 | Captured write used x8 mode |

## Verification
On every cycle, assertions check the following. A filtered strobe changes only toward a value its synchronised input already showed. An armed write always coincides with a filtered write state. A request is one clock wide and follows an armed cycle. No driver is enabled during a write request, in standby, or without a filtered read state. Which address and data sample is captured, the cancellation by output enable, the handling of simultaneous rises, the exact glitch-length boundary, and the lane masking in narrow mode can be shown only by the bench's scenarios. There, a behavioural model and the directed write, read and glitch sequences are compared clock by clock.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam int STB_N = 3;

    function automatic logic is_write(input strobe_t s);
        return !s.ce_n && !s.we_n && s.oe_n;
    endfunction

    function automatic logic is_read(input strobe_t s);
        return !s.ce_n && !s.oe_n && s.we_n;
    endfunction

endpackage

// File: rtl/pbf_sync.sv
module pbf_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;

endmodule

// File: rtl/pbf_filter.sv
module pbf_filter #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    output logic f_nxt,
    output logic f_q
);

    localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;

    typedef struct packed {
        logic          f;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = '0;
        if (s_in != st_q.f) begin
            if (st_q.cnt == CW'(FILT - 1)) begin
                st_d.f = s_in;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.f   <= 1'b1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign f_nxt = st_d.f;
    assign f_q   = st_q.f;

    assert_filter_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.f != $past(st_q.f)) |-> ($past(s_in) == st_q.f));

    generate
        if (FILT >= 2) begin : g_two
            assert_filter_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.f != $past(st_q.f)) |-> ($past(s_in, 2) == st_q.f));
        end
    endgenerate

endmodule

// File: rtl/pbf_wcap.sv
module pbf_wcap
    import pbf_pkg::*;
#(
    parameter int AW   = 18,
    parameter int DW   = 16,
    parameter int FILT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  strobe_t         stb_q,
    input  strobe_t         stb_d,
    input  logic [AW+DW:0]  smp,
    output logic            wr_req,
    output logic [AW:0]     wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic            wr_byte
);

    localparam int            TW      = AW + DW + 1;
    localparam int            LW      = DW / 2;
    localparam logic [TW-1:0] TAP_RST = {1'b1, {(TW-1){1'b0}}};

    typedef struct packed {
        logic [FILT-1:0][TW-1:0] dly;
        logic                    armed;
        logic [AW:0]             lat_addr;
        logic                    lat_byte;
        logic                    req;
        logic [AW:0]             addr;
        logic [DW-1:0]           data;
        logic                    byte_m;
    } cap_st_t;

    cap_st_t st_d, st_q;

    logic [TW-1:0] tap;
    logic          t_wide;
    logic [DW-1:0] t_dq;
    logic [AW-1:0] t_addr;
    logic          end_ev;

    assign tap    = st_q.dly[FILT-1];
    assign t_wide = tap[TW-1];
    assign t_dq   = tap[AW +: DW];
    assign t_addr = tap[AW-1:0];
    assign end_ev = (stb_d.ce_n && !stb_q.ce_n) || (stb_d.we_n && !stb_q.we_n);

    always_comb begin
        st_d        = st_q;
        st_d.req    = 1'b0;
        st_d.dly[0] = smp;
        for (int k = 1; k < FILT; k++) begin
            st_d.dly[k] = st_q.dly[k-1];
        end
        if (st_q.armed) begin
            if (!stb_d.oe_n) begin
                st_d.armed = 1'b0;
            end else if (end_ev) begin
                st_d.armed  = 1'b0;
                st_d.req    = 1'b1;
                st_d.addr   = st_q.lat_addr;
                st_d.byte_m = st_q.lat_byte;
                st_d.data   = st_q.lat_byte ? {{(DW-LW){1'b0}}, t_dq[LW-1:0]} : t_dq;
            end
        end else if (is_write(stb_d) && !is_write(stb_q)) begin
            st_d.armed    = 1'b1;
            st_d.lat_addr = {t_addr, t_wide ? 1'b0 : t_dq[DW-1]};
            st_d.lat_byte = !t_wide;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dly <= {FILT{TAP_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req  = st_q.req;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;
    assign wr_byte = st_q.byte_m;

    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> !st_q.req);

    assert_req_after_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> $past(st_q.armed));

    assert_armed_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> is_write(stb_q));

endmodule

// File: rtl/pbf_rdrv.sv
module pbf_rdrv
    import pbf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb_q,
    input  strobe_t       stb_d,
    input  logic          wide,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_oe
);

    localparam int LW = DW / 2;

    typedef struct packed {
        logic drv;
        logic narrow;
    } drv_st_t;

    drv_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.drv    = is_read(stb_d);
        st_d.narrow = !wide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < DW; g++) begin : g_lane
            if (g < LW) begin : g_low
                assign dq_oe[g] = st_q.drv;
            end else begin : g_high
                assign dq_oe[g] = st_q.drv && !st_q.narrow;
            end
            assign dq_out[g] = dq_oe[g] && rd_data[g];
        end
    endgenerate

    assert_drive_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|dq_oe) |-> is_read(stb_q));

    assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q.ce_n || stb_q.oe_n) |-> (dq_oe == '0));

endmodule

// File: rtl/pbf_front.sv
module pbf_front
    import pbf_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int FILT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_dq_in,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic [DATA_W-1:0] bus_dq_oe,
    output logic [ADDR_W:0]   rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W:0]   wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_byte
);

    localparam int            SW       = ADDR_W + DATA_W + STB_N + 1;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {STB_N{1'b1}}, {(ADDR_W+DATA_W){1'b0}}};

    logic [SW-1:0]     raw_all, s_all;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_dq;
    logic [STB_N-1:0]  s_stb, f_q_bits, f_d_bits;
    logic              s_wide;
    strobe_t           stb_q, stb_d;

    assign raw_all = {bus_wide, bus_ce_n, bus_we_n, bus_oe_n, bus_dq_in, bus_addr};

    pbf_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_all),
        .q     (s_all)
    );

    assign s_addr = s_all[ADDR_W-1:0];
    assign s_dq   = s_all[ADDR_W +: DATA_W];
    assign s_stb  = s_all[ADDR_W+DATA_W +: STB_N];
    assign s_wide = s_all[SW-1];

    generate
        for (genvar i = 0; i < STB_N; i++) begin : g_flt
            pbf_filter #(.FILT(FILT_CYC)) u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .s_in  (s_stb[i]),
                .f_nxt (f_d_bits[i]),
                .f_q   (f_q_bits[i])
            );
        end
    endgenerate

    assign stb_q = strobe_t'(f_q_bits);
    assign stb_d = strobe_t'(f_d_bits);

    pbf_wcap #(.AW(ADDR_W), .DW(DATA_W), .FILT(FILT_CYC)) u_wcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_q   (stb_q),
        .stb_d   (stb_d),
        .smp     ({s_wide, s_dq, s_addr}),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_byte (wr_byte)
    );

    pbf_rdrv #(.DW(DATA_W)) u_rdrv (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_q   (stb_q),
        .stb_d   (stb_d),
        .wide    (s_wide),
        .rd_data (rd_data),
        .dq_out  (bus_dq_out),
        .dq_oe   (bus_dq_oe)
    );

    assign rd_addr = {s_addr, s_wide ? 1'b0 : s_dq[DATA_W-1]};

    assert_write_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (bus_dq_oe == '0));

endmodule

// File: tb/tb_pbf_front.sv
`timescale 1ns/1ps
module tb_pbf_front;

    localparam int AW   = 18;
    localparam int DW   = 16;
    localparam int FILT = 3;
    localparam int H    = FILT + 3;

    typedef struct packed {
        logic          wide;
        logic          ce;
        logic          we;
        logic          oe;
        logic [DW-1:0] dq;
        logic [AW-1:0] addr;
    } raw_t;

    localparam raw_t RSTV = '{wide: 1'b1, ce: 1'b1, we: 1'b1, oe: 1'b1, dq: '0, addr: '0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    raw_t cur = RSTV;
    logic [DW-1:0] rd_data = '0;

    logic [DW-1:0] bus_dq_out, bus_dq_oe, wr_data;
    logic [AW:0]   rd_addr, wr_addr;
    logic          wr_req, wr_byte;

    always #2.5 clk = ~clk;

    pbf_front #(.ADDR_W(AW), .DATA_W(DW), .FILT_CYC(FILT)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ce_n   (cur.ce),
        .bus_we_n   (cur.we),
        .bus_oe_n   (cur.oe),
        .bus_wide   (cur.wide),
        .bus_addr   (cur.addr),
        .bus_dq_in  (cur.dq),
        .bus_dq_out (bus_dq_out),
        .bus_dq_oe  (bus_dq_oe),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_byte    (wr_byte)
    );

    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    raw_t     hq[$];
    raw_t     ms, mt;
    logic [2:0] mf, nf, sv;
    int       run[3];
    logic     m_arm, m_lbyte, m_req, m_byte, m_drv, m_nar, m_rise;
    logic [AW:0]   m_laddr, m_addr;
    logic [DW-1:0] m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq.delete();
            for (int i = 0; i < FILT + 4; i++) hq.push_front(RSTV);
            mf = 3'b111;
            for (int i = 0; i < 3; i++) run[i] = 0;
            m_arm = 0; m_lbyte = 0; m_req = 0; m_byte = 0; m_drv = 0; m_nar = 0;
            m_laddr = '0; m_addr = '0; m_data = '0;
        end else begin
            hq.push_front(cur);
            if (hq.size() > FILT + 6) void'(hq.pop_back());
            ms = hq[2];
            mt = hq[FILT + 2];
            sv = {ms.ce, ms.we, ms.oe};
            nf = mf;
            for (int i = 0; i < 3; i++) begin
                if (sv[i] != mf[i]) begin
                    run[i]++;
                    if (run[i] == FILT) begin
                        nf[i] = sv[i];
                        run[i] = 0;
                    end
                end else begin
                    run[i] = 0;
                end
            end
            m_rise = (nf[2] && !mf[2]) || (nf[1] && !mf[1]);
            m_req = 0;
            if (m_arm) begin
                if (!nf[0]) m_arm = 0;
                else if (m_rise) begin
                    m_arm  = 0;
                    m_req  = 1;
                    m_addr = m_laddr;
                    m_byte = m_lbyte;
                    m_data = m_lbyte ? {8'h00, mt.dq[7:0]} : mt.dq;
                end
            end else if (nf == 3'b001 && mf != 3'b001) begin
                m_arm   = 1;
                m_laddr = {mt.addr, mt.wide ? 1'b0 : mt.dq[DW-1]};
                m_lbyte = !mt.wide;
            end
            m_drv = (nf == 3'b010);
            m_nar = !ms.wide;
            mf = nf;
        end
    end

    int            nwr = 0;
    int            ndrv = 0;
    logic [AW:0]   last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic          last_byte = 0;
    logic [DW-1:0] e_oe, e_out;
    raw_t          h1;

    always @(negedge clk) begin
        if (rst_n) begin
            h1 = hq[1];
            e_oe  = m_drv ? (m_nar ? 16'h00FF : 16'hFFFF) : 16'h0000;
            e_out = e_oe & rd_data;
            chk("R3 wr_req vs model", 32'(wr_req), 32'(m_req));
            if (m_req && wr_req) begin
                chk("R2 wr_addr vs model", 32'(wr_addr), 32'(m_addr));
                chk("R3 wr_data vs model", 32'(wr_data), 32'(m_data));
                chk("R8 wr_byte vs model", 32'(wr_byte), 32'(m_byte));
            end
            chk("R6 dq_oe vs model", 32'(bus_dq_oe), 32'(e_oe));
            chk("R6 dq_out vs model", 32'(bus_dq_out), 32'(e_out));
            chk("R8 rd_addr vs model", 32'(rd_addr),
                32'({h1.addr, h1.wide ? 1'b0 : h1.dq[DW-1]}));
            if (wr_req) begin
                nwr++;
                last_addr = wr_addr;
                last_data = wr_data;
                last_byte = wr_byte;
            end
            if (|bus_dq_oe) ndrv++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_wr(input int order, input logic wide, input logic [AW-1:0] a,
                          input logic lsb, input logic [DW-1:0] d);
        int n0;
        n0 = nwr;
        cur.wide = wide; cur.oe = 1'b1; cur.addr = ~a;
        cur.dq = wide ? 16'h0000 : {lsb, 15'h0};
        step(H);
        if (order == 1) cur.we = 1'b0; else cur.ce = 1'b0;
        step(H);
        cur.addr = a;
        step(H);
        if (order == 1) cur.ce = 1'b0; else cur.we = 1'b0;
        step(H);
        cur.dq = wide ? d : {lsb, 7'h00, d[7:0]};
        step(H);
        if (order == 2) begin cur.ce = 1'b1; cur.we = 1'b1; end
        else if (order == 1) cur.ce = 1'b1;
        else cur.we = 1'b1;
        step(H);
        cur.dq = wide ? ~d : {lsb, 7'h7F, ~d[7:0]};
        step(H);
        cur.ce = 1'b1; cur.we = 1'b1;
        step(H);
        if (order == 2) chk("R4 single request on joint rise", 32'(nwr - n0), 32'd1);
        else            chk("R3 one request per write", 32'(nwr - n0), 32'd1);
        chk("R2 address from later fall", 32'(last_addr), 32'({a, wide ? 1'b0 : lsb}));
        chk("R3 data before first rise", 32'(last_data), 32'(wide ? d : {8'h00, d[7:0]}));
        chk("R8 byte flag", 32'(last_byte), 32'(!wide));
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        chk("R1 no request after reset", 32'(wr_req), 32'd0);
        chk("R1 no drive after reset", 32'(bus_dq_oe), 32'd0);
        step(H);
        chk("R1 idle bus stays quiet", 32'(nwr), 32'd0);

        bus_wr(0, 1'b1, 18'h12345, 1'b0, 16'hBEEF);
        bus_wr(1, 1'b1, 18'h00ABC, 1'b0, 16'h1234);
        bus_wr(2, 1'b1, 18'h3FFFF, 1'b0, 16'h8001);
        bus_wr(0, 1'b0, 18'h0F0F0, 1'b1, 16'h005A);
        bus_wr(1, 1'b0, 18'h20202, 1'b0, 16'h00C3);

        // R5: short write-enable pulse is ignored
        begin
            int n0;
            n0 = nwr;
            cur.wide = 1'b1; cur.ce = 1'b0; step(H);
            cur.we = 1'b0; step(FILT - 1);
            cur.we = 1'b1; step(H);
            cur.ce = 1'b1; step(H);
            chk("R5 short pulse gives no write", 32'(nwr - n0), 32'd0);
            n0 = nwr;
            cur.ce = 1'b0; step(H);
            cur.we = 1'b0; step(FILT);
            cur.we = 1'b1; step(H);
            cur.ce = 1'b1; step(H);
            chk("R5 pulse of threshold length accepted", 32'(nwr - n0), 32'd1);
        end

        // R9: output enable falling cancels an armed write
        begin
            int n0;
            n0 = nwr;
            cur.ce = 1'b0; step(H);
            cur.we = 1'b0; step(H);
            cur.oe = 1'b0; step(H);
            cur.we = 1'b1; step(H);
            cur.ce = 1'b1; cur.oe = 1'b1; step(H);
            chk("R9 cancelled write", 32'(nwr - n0), 32'd0);
        end

        // R2: write strobes while output enable is low
        begin
            int n0;
            n0 = nwr;
            cur.oe = 1'b0; step(H);
            cur.ce = 1'b0; step(H);
            cur.we = 1'b0; step(H);
            cur.we = 1'b1; step(H);
            cur.ce = 1'b1; cur.oe = 1'b1; step(H);
            chk("R2 no write with output enable low", 32'(nwr - n0), 32'd0);
        end

        // R6/R7 word reads
        rd_data = 16'hA5C3;
        cur.wide = 1'b1; cur.addr = 18'h0ACE5; cur.dq = 16'h8000;
        cur.ce = 1'b0; step(H);
        chk("R7 output enable high keeps bus off", 32'(bus_dq_oe), 32'h0);
        cur.oe = 1'b0; step(H);
        chk("R6 word read enables all lanes", 32'(bus_dq_oe), 32'hFFFF);
        chk("R6 word read data", 32'(bus_dq_out), 32'hA5C3);
        chk("R8 word address lsb is zero", 32'(rd_addr), 32'({18'h0ACE5, 1'b0}));
        cur.ce = 1'b1; step(H);
        chk("R7 standby releases bus", 32'(bus_dq_oe), 32'h0);
        cur.oe = 1'b1; step(H);

        // R5: short output-enable glitch during a would-be read
        begin
            int d0;
            d0 = ndrv;
            cur.ce = 1'b0; step(H);
            cur.oe = 1'b0; step(FILT - 1);
            cur.oe = 1'b1; step(H);
            chk("R5 output enable glitch ignored", 32'(ndrv - d0), 32'd0);
            cur.ce = 1'b1; step(H);
        end

        // R8 byte read
        cur.wide = 1'b0; cur.addr = 18'h12345; cur.dq = 16'h8000;
        cur.ce = 1'b0; cur.oe = 1'b0; step(H);
        chk("R8 byte read lanes", 32'(bus_dq_oe), 32'h00FF);
        chk("R8 byte read data", 32'(bus_dq_out), 32'h00C3);
        chk("R8 byte read address lsb", 32'(rd_addr), 32'({18'h12345, 1'b1}));
        cur.ce = 1'b1; cur.oe = 1'b1; step(H);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule